// File: doc/BRIEF.md
# Multicycle Instruction Sequencer for an 8-bit Core

This block is the control heart of a small 8-bit processor. It reads each 16-bit instruction word one byte per cycle from a byte-wide memory with a synchronous read port, taking the more significant byte first. It then decodes the word into an opcode, a destination register index, a source register index and an 8-bit immediate, and sequences its execution. Five opcodes carry a second 16-bit word holding an absolute byte address: load, store, unconditional jump, conditional jump and call. The sequencer fetches that word too, so these instructions take four bytes. All other instructions take two bytes.

The core holds four 8-bit general registers, a 4-bit flag register, the program counter and a downward-growing stack pointer. Arithmetic is not done here. The sequencer presents the opcode and both register operands to an external ALU, then takes back an 8-bit result and four flags. Branch decisions are also external: the sequencer hands the latched flags and a 3-bit condition selector to a condition unit, which answers taken or not taken. There is no load-immediate. Constants must be read from memory. The halt opcode freezes the core until the next reset. The address width is the parameter `AW`.

Top module: `insn_sequencer`

## Requirements
- R1: Reset clears the PC, the four registers and the flags, and sets SP to all ones (the highest byte address). In the first cycle after reset, `mem_rd` is high with `mem_addr` = 0, and `halted` is low.
- R2: An instruction word is read as two consecutive bytes, the byte at PC forming bits 15..8. Bits 15..12 are the opcode, 11..10 rd, 9..8 rs and 7..0 imm8. Opcodes 0x0 to 0x9 advance the PC by 2.
- R3: Opcodes 0xA to 0xE read the bytes at PC+2 and PC+3 as a big-endian 16-bit address, of which the low `AW` bits are used. These opcodes advance the PC by 4 unless they redirect it.
- R4: For opcodes 0x0 to 0x8, `alu_op` carries the opcode, `alu_a` carries R[rd] and `alu_b` carries R[rs`]`. `alu_res` is written to R[rd] and `alu_flags` (bit order Z,N,C,V from bit 3 down) is latched into the flags.
- R5: Opcode 0x9 (compare) latches `alu_flags` into the flags and leaves R[rd] unchanged.
- R6: Opcode 0xA (load) reads the byte at the address word into R[rd].
- R7: Opcode 0xB (store) writes R[rs] to the address word, with `mem_wr` high for one cycle.
- R8: Opcode 0xC (jump) sets the PC to the address word.
- R9: Opcode 0xD (conditional jump) drives `cond_sel` = imm8[2:0] and `cond_flags` = the latched flags. It sets the PC to the address word when `cond_taken` is high, and to PC+4 otherwise.
- R10: Opcode 0xE (call) first writes bits 15..8 of the 16-bit return address PC+4 at SP, then writes bits 7..0 at SP-1 in the next cycle. It then lowers SP by 2 and sets the PC to the address word.
- R11: Opcode 0xF raises `halted`. From then until reset, no memory read or write occurs and the flags stay put.
- R12: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | AW | Byte address for the current memory access |
| mem_rd | output | 1 | Read request; data returns on `mem_rdata` the next cycle |
| mem_wr | output | 1 | Write strobe for `mem_wdata` at `mem_addr` |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data from the previous cycle's request |
| alu_op | output | 4 | Opcode for the external ALU |
| alu_a | output | 8 | First operand, R[rd] |
| alu_b | output | 8 | Second operand, R[rs] |
| alu_res | input | 8 | ALU result |
| alu_flags | input | 4 | ALU flags {Z,N,C,V} |
| cond_sel | output | 3 | Branch condition selector, imm8[2:0] |
| cond_flags | output | 4 | Latched flags {Z,N,C,V} |
| cond_taken | input | 1 | Condition unit verdict |
| halted | output | 1 | High once the halt opcode has executed |

## Verification
The bench goes after several corner cases, each of which a wrong design would get wrong in a visible way.

- **Conditional jumps that fall through.** They must still skip the address word. A core that advanced by 2 would execute address bytes as instructions.
- **Compare.** A core that wrote back on compare would corrupt the register stored afterwards.
- **Back-to-back calls.** These check the byte order and the SP step. Swapped halves or a single-byte step would leave the wrong bytes at the stack top.
- **Execution after halt.** A core that kept fetching after halt would show reads or writes on the memory port.

Random programs mix every opcode, including all eight branch conditions. Each run ends by dumping the registers to memory, so any slip in fetch alignment or writeback surfaces as a memory mismatch against a bench instruction-level model.

// File: rtl/insn_sequencer.sv
module insn_sequencer #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic [3:0]    alu_op,
  output logic [7:0]    alu_a,
  output logic [7:0]    alu_b,
  input  logic [7:0]    alu_res,
  input  logic [3:0]    alu_flags,
  output logic [2:0]    cond_sel,
  output logic [3:0]    cond_flags,
  input  logic          cond_taken,
  output logic          halted
);

  localparam logic [3:0] OP_CMP   = 4'h9;
  localparam logic [3:0] OP_LOAD  = 4'hA;
  localparam logic [3:0] OP_STORE = 4'hB;
  localparam logic [3:0] OP_JMP   = 4'hC;
  localparam logic [3:0] OP_JCC   = 4'hD;
  localparam logic [3:0] OP_CALL  = 4'hE;
  localparam logic [3:0] OP_HALT  = 4'hF;

  typedef enum logic [3:0] {
    S_F0, S_F1, S_F2, S_A1, S_A2, S_EXS, S_EXA, S_LD, S_PUSH, S_HALT
  } state_t;

  state_t        st;
  logic [AW-1:0] pc, sp;
  logic [15:0]   ir, tgt;
  logic [7:0]    rf [4];
  logic [3:0]    flags;

  logic [3:0]    opc;
  logic [1:0]    rd, rs;
  logic          ext;
  logic [AW-1:0] pc2, pc4, tgt_a;
  logic [15:0]   ret;

  assign opc   = ir[15:12];
  assign rd    = ir[11:10];
  assign rs    = ir[9:8];
  assign ext   = (opc >= OP_LOAD) && (opc <= OP_CALL);
  assign pc2   = pc + AW'(2);
  assign pc4   = pc + AW'(4);
  assign tgt_a = tgt[AW-1:0];
  assign ret   = 16'(pc4);

  assign alu_op     = opc;
  assign alu_a      = rf[rd];
  assign alu_b      = rf[rs];
  assign cond_sel   = ir[2:0];
  assign cond_flags = flags;
  assign halted     = (st == S_HALT);

  always_comb begin
    mem_addr  = pc;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_wdata = 8'h00;
    case (st)
      S_F0: mem_rd = 1'b1;
      S_F1: begin mem_rd = 1'b1; mem_addr = pc + AW'(1); end
      S_F2: if (ext) begin mem_rd = 1'b1; mem_addr = pc2; end
      S_A1: begin mem_rd = 1'b1; mem_addr = pc + AW'(3); end
      S_EXA: begin
        case (opc)
          OP_LOAD:  begin mem_rd = 1'b1; mem_addr = tgt_a; end
          OP_STORE: begin mem_wr = 1'b1; mem_addr = tgt_a; mem_wdata = rf[rs]; end
          OP_CALL:  begin mem_wr = 1'b1; mem_addr = sp; mem_wdata = ret[15:8]; end
          default: ;
        endcase
      end
      S_PUSH: begin mem_wr = 1'b1; mem_addr = sp - AW'(1); mem_wdata = ret[7:0]; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_F0;
      pc    <= '0;
      sp    <= '1;
      ir    <= '0;
      tgt   <= '0;
      flags <= '0;
      for (int i = 0; i < 4; i++) rf[i] <= '0;
    end else begin
      case (st)
        S_F0: st <= S_F1;
        S_F1: begin ir[15:8] <= mem_rdata; st <= S_F2; end
        S_F2: begin ir[7:0] <= mem_rdata; st <= ext ? S_A1 : S_EXS; end
        S_A1: begin tgt[15:8] <= mem_rdata; st <= S_A2; end
        S_A2: begin tgt[7:0] <= mem_rdata; st <= S_EXA; end
        S_EXS: begin
          if (opc == OP_HALT) begin
            st <= S_HALT;
          end else begin
            flags <= alu_flags;
            if (opc != OP_CMP) rf[rd] <= alu_res;
            pc <= pc2;
            st <= S_F0;
          end
        end
        S_EXA: begin
          st <= S_F0;
          case (opc)
            OP_LOAD:  st <= S_LD;
            OP_STORE: pc <= pc4;
            OP_JMP:   pc <= tgt_a;
            OP_JCC:   pc <= cond_taken ? tgt_a : pc4;
            OP_CALL:  st <= S_PUSH;
            default:  pc <= pc4;
          endcase
        end
        S_LD: begin rf[rd] <= mem_rdata; pc <= pc4; st <= S_F0; end
        S_PUSH: begin sp <= sp - AW'(2); pc <= tgt_a; st <= S_F0; end
        default: st <= S_HALT;
      endcase
    end
  end

endmodule

// File: rtl/insn_sequencer_chk.sv
module insn_sequencer_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [AW-1:0] mem_addr,
  input logic          halted,
  input logic [AW-1:0] sp,
  input logic [3:0]    flags
);

  a_r12_rw_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  a_r11_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_rd && !mem_wr));

  a_r11_flags_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(flags));

  a_r10_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sp) |-> (sp == AW'($past(sp) - AW'(2))));

  a_r10_push_descends: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && $past(mem_wr)) |-> (mem_addr == AW'($past(mem_addr) - AW'(1))));

endmodule

bind insn_sequencer insn_sequencer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_addr(mem_addr), .halted(halted), .sp(sp), .flags(flags)
);

// File: tb/insn_sequencer_test.sv
module insn_sequencer_test;
  localparam int AW = 8;
  localparam int MS = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] mem_addr;
  logic mem_rd, mem_wr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [3:0] alu_op;
  logic [7:0] alu_a, alu_b, alu_res;
  logic [3:0] alu_flags, cond_flags;
  logic [2:0] cond_sel;
  logic cond_taken, halted;

  int n_tests = 0, n_fail = 0;
  bit rw_overlap = 0;
  logic [7:0] mem [MS];
  logic [7:0] ref_mem [MS];
  logic [3:0] ref_flags;
  int pp;

  always #10 clk = ~clk;

  insn_sequencer #(.AW(AW)) uut (.*);

  function automatic logic [11:0] alu_f(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
    logic [8:0] w; logic [7:0] r; logic c, v;
    c = 0; v = 0; r = 0;
    case (op)
      4'h0: begin w = {1'b0,a} + {1'b0,b}; r = w[7:0]; c = w[8]; v = (a[7]==b[7]) && (r[7]!=a[7]); end
      4'h1, 4'h9: begin w = {1'b0,a} - {1'b0,b}; r = w[7:0]; c = w[8]; v = (a[7]!=b[7]) && (r[7]!=a[7]); end
      4'h2: r = a & b;
      4'h3: r = a | b;
      4'h4: r = a ^ b;
      4'h5: begin r = a << 1; c = a[7]; end
      4'h6: begin r = a >> 1; c = a[0]; end
      4'h7: r = 8'(a * b);
      4'h8: r = (b == 0) ? 8'hFF : a / b;
      default: r = 0;
    endcase
    return {r == 0, r[7], c, v, r};
  endfunction

  function automatic logic cond_f(input logic [2:0] s, input logic [3:0] f);
    logic b;
    case (s[2:1])
      2'd0: b = f[3];
      2'd1: b = f[1];
      2'd2: b = f[2];
      default: b = f[0];
    endcase
    return s[0] ? !b : b;
  endfunction

  always_comb begin
    {alu_flags, alu_res} = alu_f(alu_op, alu_a, alu_b);
    cond_taken = cond_f(cond_sel, cond_flags);
  end

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] <= mem_wdata;
  end

  always @(negedge clk) if (rst_n && mem_rd && mem_wr) rw_overlap = 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic emit(input int op, input int rd, input int rs, input int imm);
    mem[pp] = 8'((op << 4) | (rd << 2) | rs);
    mem[pp+1] = 8'(imm);
    pp += 2;
  endtask

  task automatic emit_a(input int op, input int rd, input int rs, input int imm, input int ad);
    emit(op, rd, rs, imm);
    mem[pp] = 8'(ad >> 8);
    mem[pp+1] = 8'(ad);
    pp += 2;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < MS; i++) mem[i] = (i >= 160 && i < 232) ? 8'($urandom) : 8'h00;
    pp = 0;
  endtask

  task automatic iss();
    int pc, sp, op, rd, rs, ad, ret;
    logic [7:0] r [4];
    logic [11:0] fr;
    logic [3:0] f;
    pc = 0; sp = MS - 1; f = 0;
    for (int i = 0; i < 4; i++) r[i] = 0;
    for (int st = 0; st < 4000; st++) begin
      op = ref_mem[pc] >> 4; rd = (ref_mem[pc] >> 2) & 3; rs = ref_mem[pc] & 3;
      ad = ((ref_mem[(pc+2)%MS] << 8) | ref_mem[(pc+3)%MS]) % MS;
      if (op == 15) break;
      if (op <= 9) begin
        fr = alu_f(4'(op), r[rd], r[rs]);
        f = fr[11:8];
        if (op != 9) r[rd] = fr[7:0];
        pc = (pc + 2) % MS;
      end else begin
        ret = (pc + 4) % MS;
        case (op)
          10: begin r[rd] = ref_mem[ad]; pc = ret; end
          11: begin ref_mem[ad] = r[rs]; pc = ret; end
          12: pc = ad;
          13: pc = cond_f(ref_mem[(pc+1)%MS][2:0], f) ? ad : ret;
          default: begin
            ref_mem[sp] = 8'(ret >> 8);
            ref_mem[(sp+MS-1)%MS] = 8'(ret);
            sp = (sp + MS - 2) % MS;
            pc = ad;
          end
        endcase
      end
    end
    ref_flags = f;
  endtask

  task automatic run_prog(input string req, input bit check_reset);
    int cyc, bad;
    for (int i = 0; i < MS; i++) ref_mem[i] = mem[i];
    iss();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    #1;
    if (check_reset) begin
      check(mem_rd && !mem_wr && mem_addr == 0, "R1 first fetch", {mem_rd, mem_wr, mem_addr}, 'h200);
      check(!halted && cond_flags == 0, "R1 halted/flags", {halted, cond_flags}, 0);
    end
    cyc = 0;
    while (!halted && cyc < 8000) begin @(negedge clk); cyc++; end
    check(halted, {req, " halt reached"}, halted, 1);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (mem_rd || mem_wr) begin check(0, "R11 port quiet after halt", {mem_rd, mem_wr}, 0); break; end
    end
    bad = -1;
    for (int i = 0; i < MS; i++) if (mem[i] !== ref_mem[i] && bad < 0) bad = i;
    if (bad < 0) check(1, req, 0, 0);
    else check(0, {req, " memory"}, (bad << 8) | mem[bad], (bad << 8) | ref_mem[bad]);
    check(cond_flags == ref_flags, {req, " R5 flags"}, cond_flags, ref_flags);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R4 R6 R7: loads, arithmetic writeback, store
    clear_mem();
    mem[200] = 8'h5A; mem[201] = 8'hC3;
    emit_a(10, 1, 0, 0, 200); emit_a(10, 2, 0, 0, 201);
    emit(0, 1, 2, 0); emit_a(11, 0, 1, 0, 210);
    emit(7, 2, 1, 0); emit_a(11, 0, 2, 0, 211);
    emit(8, 2, 0, 0); emit_a(11, 0, 2, 0, 212);
    emit(15, 0, 0, 0);
    run_prog("R1 R2 R4 R6 R7 arithmetic", 1);

    // R5: compare leaves destination intact
    clear_mem();
    mem[200] = 8'h10; mem[201] = 8'h20;
    emit_a(10, 0, 0, 0, 200); emit_a(10, 1, 0, 0, 201);
    emit(9, 0, 1, 0); emit_a(11, 0, 0, 0, 210); emit(15, 0, 0, 0);
    run_prog("R5 compare", 0);

    // R10: two nested calls, stack byte order and SP step
    clear_mem();
    emit_a(14, 0, 0, 0, 6); emit(15, 0, 0, 0);
    emit_a(14, 0, 0, 0, 12); emit(15, 0, 0, 0);
    emit_a(11, 0, 0, 0, 220); emit(15, 0, 0, 0);
    run_prog("R10 call push", 0);

    // R8 R3: jump over halt
    clear_mem();
    emit_a(12, 0, 0, 0, 8); emit(15, 0, 0, 0); emit(15, 0, 0, 0);
    emit_a(10, 3, 0, 0, 170); emit_a(11, 0, 3, 0, 221); emit(15, 0, 0, 0);
    run_prog("R8 R3 jump", 0);

    // R9: every condition, taken or not, skipping a store
    clear_mem();
    mem[200] = 8'h7F; mem[201] = 8'h80;
    emit_a(10, 0, 0, 0, 200); emit_a(10, 1, 0, 0, 201);
    for (int c = 0; c < 8; c++) begin
      emit(c < 4 ? 1 : 0, 0, 1, 0);
      emit_a(13, 0, 0, c, pp + 8);
      emit_a(11, 0, 0, 0, 210 + c);
    end
    emit(15, 0, 0, 0);
    run_prog("R9 R3 conditions", 0);

    // random programs R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int t = 0; t < 40; t++) begin
      int calls;
      clear_mem();
      calls = 0;
      while (pp < 130) begin
        int k;
        k = $urandom % 10;
        case (k)
          0, 1, 2, 3: emit($urandom % 9, $urandom % 4, $urandom % 4, $urandom % 256);
          4: emit_a(10, $urandom % 4, $urandom % 4, $urandom % 256, 160 + $urandom % 72);
          5: emit_a(11, $urandom % 4, $urandom % 4, $urandom % 256, 160 + $urandom % 72);
          6: begin emit_a(13, 0, 0, $urandom % 8, pp + 6); emit($urandom % 9, $urandom % 4, $urandom % 4, 0); end
          7: begin emit_a(12, 0, 0, 0, pp + 6); emit(15, 0, 0, 0); end
          8: if (calls < 6) begin calls++; emit_a(14, 0, 0, 0, pp + 6); emit(15, 0, 0, 0); end
          default: emit(9, $urandom % 4, $urandom % 4, 0);
        endcase
      end
      for (int r = 0; r < 4; r++) emit_a(11, 0, r, 0, 232 + r);
      emit(15, 0, 0, 0);
      run_prog("R2 R3 R4 R9 R10 random program", 0);
    end

    check(!rw_overlap, "R12 read/write exclusive", rw_overlap, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule